// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block sits between one processor and a shared single-transaction bus. It keeps a small direct-mapped cache of one-word lines, and each line carries its own sharing status. There is no central directory. Each controller watches every bus transaction that another controller drives and updates its own copies from what it sees. A processor write must hold the line exclusively before it completes. A write to a line that other caches may also hold first broadcasts an invalidate. A controller that holds a dirty copy answers other caches' misses from that copy, so memory does not answer.

Each line is in one of three states: Invalid, Shared or Modified. The control machine uses these states:
- IDLE accepts a request.
- TAG looks up the line.
- WBACK writes back a dirty victim.
- UPGR broadcasts an invalidate for a write hit on a Shared line.
- FILL issues a read miss or a write miss.
- DONE returns the result to the processor.

The transitions are:
- IDLE→TAG on `cpu_req`.
- TAG→TAG when a snoop touches the same index in that cycle.
- TAG→DONE on a read hit or on a write hit to a Modified line.
- TAG→UPGR on a write hit to a Shared line.
- TAG→WBACK on a miss whose victim is Modified.
- TAG→FILL on any other miss.
- WBACK→FILL when the write-back is granted, or when a snoop has already taken the dirty victim away.
- UPGR→DONE when the invalidate is granted.
- UPGR→FILL when the line was invalidated while waiting for the bus.
- FILL→DONE when the fill is granted.
- DONE→IDLE.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done`, `bus_req` and `snp_supply` are low. The first access to any address therefore goes to the bus.
- R2: A read that misses drives a transaction with `bus_cmd_o`=1 (read miss) and the request address. It loads the returned `bus_rdata` as Shared and returns that value on `cpu_rdata` while `cpu_done` is high. A later read of the same address completes with no bus transaction.
- R3: A write to an address that is not held drives `bus_cmd_o`=2 (write miss) and leaves the line Modified. Later reads and writes of that address complete with no bus transaction. For every write, `cpu_rdata` in the done cycle equals the written data.
- R4: A write that hits a Shared line drives `bus_cmd_o`=3 (invalidate) and does not fetch data. Once that transaction is granted, the line is Modified and the write completes.
- R5: A snooped invalidate or write miss from another controller whose address matches a valid line makes that line Invalid. The next read of it by this controller misses and receives the new value.
- R6: A snooped read miss or write miss that matches a Modified line raises `snp_supply` with the line's data on `snp_data` in the same cycle. A read miss leaves the line Shared, so a later own write issues an invalidate. A write miss leaves the line Invalid.
- R7: A miss whose victim line is Modified first drives `bus_cmd_o`=4 (write-back) carrying the victim's address and data. Only after that does it drive the read or write miss for the new address.
- R8: A miss whose victim line is Shared drives no write-back.
- R9: A transaction takes place only in a cycle in which `bus_req` and `bus_gnt` are both high. A controller that is not granted keeps the same request. Of two writers to one Shared line, the one granted first wins. The other's pending invalidate becomes a write miss, and that write miss fetches the winner's data.
- R10: If a snoop takes a Modified victim to Shared or Invalid while its write-back waits for the bus, the write-back is dropped and the fill follows.
- R11: The line index is the low log2(LINES) address bits, and the tag is the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse, taken while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request word address |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | DW | Line data, valid with cpu_done |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd_o | output | 3 | Own command: 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr_o | output | AW | Own transaction address |
| bus_data_o | output | DW | Own write-back data |
| bus_valid | input | 1 | A transaction is on the bus this cycle |
| bus_cmd_i | input | 3 | Command currently on the bus |
| bus_addr_i | input | AW | Address currently on the bus |
| bus_rdata | input | DW | Data answering a miss (from a supplying cache or memory) |
| snp_supply | output | 1 | This cache answers the current snooped miss |
| snp_data | output | DW | Data supplied with snp_supply |

## Verification
The bench builds two controllers with AW=8, DW=16 and LINES=4. With only four lines, addresses that differ in bit 2 or above collide on one index, so dirty and clean evictions each take a single extra access. A bench arbiter with fixed priority for the second controller makes both races deterministic: the simultaneous upgrade of one Shared line, and a write-back that a competing read miss overtakes.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        BC_IDLE   = 3'd0,
        BC_RDMISS = 3'd1,
        BC_WRMISS = 3'd2,
        BC_INVAL  = 3'd3,
        BC_WBACK  = 3'd4
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_TAG,
        CS_WBACK,
        CS_UPGR,
        CS_FILL,
        CS_DONE
    } ctl_st_e;
endpackage

// File: rtl/snoop_line_store.sv
module snoop_line_store
    import snoop_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 6,
    parameter int DW    = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_e         a_st,
    output logic [TAG_W-1:0] a_tag,
    output logic [DW-1:0]    a_data,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_e         b_st,
    output logic [TAG_W-1:0] b_tag,
    output logic [DW-1:0]    b_data,
    input  logic             own_we,
    input  logic [IDX_W-1:0] own_idx,
    input  line_st_e         own_st,
    input  logic [TAG_W-1:0] own_tag,
    input  logic [DW-1:0]    own_data,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st
);
    line_st_e         st_q   [LINES];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [DW-1:0]    data_q [LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i] <= LN_INV;
            end else if (own_we && own_idx == IDX_W'(i)) begin
                st_q[i] <= own_st;
            end else if (snp_we && snp_idx == IDX_W'(i)) begin
                st_q[i] <= snp_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (own_we) begin
            tag_q[own_idx]  <= own_tag;
            data_q[own_idx] <= own_data;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    // R5
    own_snp_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_we && snp_we && own_idx == snp_idx));
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
    import snoop_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int DW    = 16
) (
    input  logic             bus_valid,
    input  logic             own_active,
    input  bus_cmd_e         bus_cmd,
    input  logic [TAG_W-1:0] bus_tag,
    input  line_st_e         b_st,
    input  logic [TAG_W-1:0] b_tag,
    input  logic [DW-1:0]    b_data,
    output logic             snp_we,
    output line_st_e         snp_st,
    output logic             supply,
    output logic [DW-1:0]    supply_data
);
    logic match;

    assign match = bus_valid && !own_active && (b_st != LN_INV) && (b_tag == bus_tag);

    always_comb begin
        snp_we      = 1'b0;
        snp_st      = b_st;
        supply      = 1'b0;
        supply_data = b_data;
        if (match) begin
            unique case (bus_cmd)
                BC_RDMISS: begin
                    if (b_st == LN_MOD) begin
                        snp_we = 1'b1;
                        snp_st = LN_SHR;
                        supply = 1'b1;
                    end
                end
                BC_WRMISS: begin
                    snp_we = 1'b1;
                    snp_st = LN_INV;
                    supply = (b_st == LN_MOD);
                end
                BC_INVAL: begin
                    snp_we = 1'b1;
                    snp_st = LN_INV;
                end
                default: begin
                    snp_we = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/snoop_ctl_fsm.sv
module snoop_ctl_fsm
    import snoop_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int LINES = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = AW - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_done,
    output logic [DW-1:0]    cpu_rdata,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic [DW-1:0]    bus_rdata,
    output bus_cmd_e         cmd_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic [IDX_W-1:0] a_idx,
    input  line_st_e         a_st,
    input  logic [TAG_W-1:0] a_tag,
    input  logic [DW-1:0]    a_data,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             own_we,
    output line_st_e         own_st,
    output logic [TAG_W-1:0] own_tag,
    output logic [DW-1:0]    own_data
);
    ctl_st_e          st_q, st_d;
    logic             rq_we;
    logic [AW-1:0]    rq_addr;
    logic [DW-1:0]    rq_data;
    logic [IDX_W-1:0] rq_idx;
    logic [TAG_W-1:0] rq_tag;
    logic             hit, granted, snp_clash;

    assign rq_idx    = rq_addr[IDX_W-1:0];
    assign rq_tag    = rq_addr[AW-1:IDX_W];
    assign a_idx     = rq_idx;
    assign hit       = (a_st != LN_INV) && (a_tag == rq_tag);
    assign granted   = bus_req && bus_gnt;
    assign snp_clash = snp_we && (snp_idx == rq_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CS_IDLE;
            rq_we   <= 1'b0;
            rq_addr <= '0;
            rq_data <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == CS_IDLE && cpu_req) begin
                rq_we   <= cpu_we;
                rq_addr <= cpu_addr;
                rq_data <= cpu_wdata;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_IDLE:  if (cpu_req) st_d = CS_TAG;
            CS_TAG: begin
                if (snp_clash)                        st_d = CS_TAG;
                else if (hit && (!rq_we || a_st == LN_MOD)) st_d = CS_DONE;
                else if (hit)                         st_d = CS_UPGR;
                else if (a_st == LN_MOD)              st_d = CS_WBACK;
                else                                  st_d = CS_FILL;
            end
            CS_WBACK: if (a_st != LN_MOD || granted) st_d = CS_FILL;
            CS_UPGR: begin
                if (!(a_st == LN_SHR && a_tag == rq_tag)) st_d = CS_FILL;
                else if (granted)                        st_d = CS_DONE;
            end
            CS_FILL:  if (granted) st_d = CS_DONE;
            CS_DONE:  st_d = CS_IDLE;
            default:  st_d = CS_IDLE;
        endcase
    end

    always_comb begin
        cpu_done  = 1'b0;
        cpu_rdata = a_data;
        bus_req   = 1'b0;
        cmd_o     = BC_IDLE;
        addr_o    = rq_addr;
        data_o    = rq_data;
        own_we    = 1'b0;
        own_st    = LN_MOD;
        own_tag   = rq_tag;
        own_data  = rq_data;
        unique case (st_q)
            CS_IDLE: ;
            CS_TAG: begin
                own_we = !snp_clash && hit && rq_we && (a_st == LN_MOD);
            end
            CS_WBACK: begin
                bus_req  = (a_st == LN_MOD);
                cmd_o    = BC_WBACK;
                addr_o   = {a_tag, rq_idx};
                data_o   = a_data;
                own_we   = granted;
                own_st   = LN_INV;
                own_tag  = a_tag;
                own_data = a_data;
            end
            CS_UPGR: begin
                bus_req = (a_st == LN_SHR) && (a_tag == rq_tag);
                cmd_o   = BC_INVAL;
                own_we  = granted;
            end
            CS_FILL: begin
                bus_req  = 1'b1;
                cmd_o    = rq_we ? BC_WRMISS : BC_RDMISS;
                own_we   = granted;
                own_st   = rq_we ? LN_MOD : LN_SHR;
                own_data = rq_we ? rq_data : bus_rdata;
            end
            CS_DONE: cpu_done = 1'b1;
            default: ;
        endcase
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_we) |=> (bus_req && $stable(cmd_o) && $stable(addr_o)));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    // R2
    rd_fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && cmd_o == BC_RDMISS) |=> cpu_done);
    // R4
    upgr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && cmd_o == BC_INVAL) |=> cpu_done);
    // R7
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && cmd_o == BC_WBACK) |=> (bus_req && (cmd_o == BC_RDMISS || cmd_o == BC_WRMISS)));
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snoop_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int LINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [2:0]    bus_cmd_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_data_o,
    input  logic          bus_valid,
    input  logic [2:0]    bus_cmd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_rdata,
    output logic          snp_supply,
    output logic [DW-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = AW - IDX_W;

    logic [IDX_W-1:0] a_idx, b_idx;
    line_st_e         a_st, b_st, own_st, snp_st;
    logic [TAG_W-1:0] a_tag, b_tag, own_tag, bus_tag;
    logic [DW-1:0]    a_data, b_data, own_data;
    logic             own_we, snp_we, own_active;
    bus_cmd_e         cmd_e;

    assign b_idx      = bus_addr_i[IDX_W-1:0];
    assign bus_tag    = bus_addr_i[AW-1:IDX_W];
    assign own_active = bus_req && bus_gnt;
    assign bus_cmd_o  = cmd_e;

    snoop_ctl_fsm #(.AW(AW), .DW(DW), .LINES(LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .cmd_o(cmd_e), .addr_o(bus_addr_o), .data_o(bus_data_o),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .snp_we(snp_we), .snp_idx(b_idx),
        .own_we(own_we), .own_st(own_st), .own_tag(own_tag), .own_data(own_data)
    );

    snoop_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .own_we(own_we), .own_idx(a_idx), .own_st(own_st), .own_tag(own_tag), .own_data(own_data),
        .snp_we(snp_we), .snp_idx(b_idx), .snp_st(snp_st)
    );

    snoop_responder #(.TAG_W(TAG_W), .DW(DW)) u_resp (
        .bus_valid(bus_valid), .own_active(own_active),
        .bus_cmd(bus_cmd_e'(bus_cmd_i)), .bus_tag(bus_tag),
        .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .snp_we(snp_we), .snp_st(snp_st),
        .supply(snp_supply), .supply_data(snp_data)
    );
endmodule

// File: tb/sim_snoop_cache_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_cache_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req0 = 0, we0 = 0, req1 = 0, we1 = 0;
    logic [AW-1:0] addr0 = 0, addr1 = 0;
    logic [DW-1:0] wd0 = 0, wd1 = 0;
    logic          done0, done1, breq0, breq1, sup0, sup1;
    logic [DW-1:0] rd0, rd1, bd0, bd1, sd0, sd1;
    logic [2:0]    cmd0, cmd1;
    logic [AW-1:0] ba0, ba1;
    logic          g0, g1, bvalid;
    logic [2:0]    bcmd;
    logic [AW-1:0] baddr;
    logic [DW-1:0] bdata, brdata;
    logic [DW-1:0] mem [256];

    // arbiter: cache 1 wins ties
    assign g1     = breq1;
    assign g0     = breq0 && !breq1;
    assign bvalid = g0 || g1;
    assign bcmd   = g1 ? cmd1 : (g0 ? cmd0 : 3'd0);
    assign baddr  = g1 ? ba1 : ba0;
    assign bdata  = g1 ? bd1 : bd0;
    assign brdata = sup0 ? sd0 : (sup1 ? sd1 : mem[baddr]);

    initial for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
    always @(posedge clk) begin
        if (bvalid) begin
            if (bcmd == 3'd4) mem[baddr] <= bdata;
            else if (sup0 || sup1) mem[baddr] <= brdata;
        end
    end

    snoop_cache_ctrl #(.AW(AW), .DW(DW), .LINES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(req0), .cpu_we(we0), .cpu_addr(addr0), .cpu_wdata(wd0),
        .cpu_done(done0), .cpu_rdata(rd0), .bus_req(breq0), .bus_gnt(g0),
        .bus_cmd_o(cmd0), .bus_addr_o(ba0), .bus_data_o(bd0),
        .bus_valid(bvalid), .bus_cmd_i(bcmd), .bus_addr_i(baddr), .bus_rdata(brdata),
        .snp_supply(sup0), .snp_data(sd0));
    snoop_cache_ctrl #(.AW(AW), .DW(DW), .LINES(4)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(req1), .cpu_we(we1), .cpu_addr(addr1), .cpu_wdata(wd1),
        .cpu_done(done1), .cpu_rdata(rd1), .bus_req(breq1), .bus_gnt(g1),
        .bus_cmd_o(cmd1), .bus_addr_o(ba1), .bus_data_o(bd1),
        .bus_valid(bvalid), .bus_cmd_i(bcmd), .bus_addr_i(baddr), .bus_rdata(brdata),
        .snp_supply(sup1), .snp_data(sd1));

    int total = 0, bad = 0;
    int dcnt0 = 0, dcnt1 = 0;
    logic [DW-1:0] refm [256];
    logic [DW-1:0] q0 [$], q1 [$];
    string         r0 [$], r1 [$];
    int lsrc [$], lsup [$], lcmd [$], laddr [$], ldata [$];

    initial for (int i = 0; i < 256; i++) refm[i] = 16'h1000 + 16'(i);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor and bus logger
    always @(negedge clk) begin
        if (rst_n && done0) begin
            if (q0.size() == 0) chk("R2 unexpected done0", 1, 0);
            else chk(r0.pop_front(), int'(rd0), int'(q0.pop_front()));
            dcnt0++;
        end
        if (rst_n && done1) begin
            if (q1.size() == 0) chk("R2 unexpected done1", 1, 0);
            else chk(r1.pop_front(), int'(rd1), int'(q1.pop_front()));
            dcnt1++;
        end
        if (rst_n && bvalid) begin
            lsrc.push_back(g1 ? 1 : 0);
            lsup.push_back((sup0 || sup1) ? 1 : 0);
            lcmd.push_back(int'(bcmd));
            laddr.push_back(int'(baddr));
            ldata.push_back(int'(bdata));
        end
    end

    task automatic clear_log();
        lsrc.delete(); lsup.delete(); lcmd.delete(); laddr.delete(); ldata.delete();
    endtask

    task automatic expect_ent(input string req, input int i, input int src, input int cmd,
                              input int a, input int sup);
        int act;
        act = (i < lcmd.size()) ? lsrc[i]*100000 + lsup[i]*10000 + lcmd[i]*1000 + laddr[i] : -1;
        chk(req, act, src*100000 + sup*10000 + cmd*1000 + a);
    endtask

    task automatic do_op(input int p, input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string req);
        logic [DW-1:0] e;
        int start;
        e = w ? d : refm[a];
        if (w) refm[a] = d;
        @(negedge clk);
        if (p == 0) begin
            q0.push_back(e); r0.push_back(req); start = dcnt0;
            req0 = 1; we0 = w; addr0 = a; wd0 = d;
        end else begin
            q1.push_back(e); r1.push_back(req); start = dcnt1;
            req1 = 1; we1 = w; addr1 = a; wd1 = d;
        end
        @(negedge clk);
        if (p == 0) req0 = 0; else req1 = 0;
        wait ((p == 0 ? dcnt0 : dcnt1) != start);
    endtask

    localparam logic [AW-1:0] X = 8'h10, Y = 8'h14, Z = 8'h21, W = 8'h25, V = 8'h32;

    initial begin
        repeat (50000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 done0 after reset", int'(done0), 0);
        chk("R1 bus_req after reset", int'(breq0 | breq1), 0);
        chk("R1 supply after reset", int'(sup0 | sup1), 0);

        clear_log(); do_op(0, 0, X, 0, "R1 R2 first read data");
        chk("R1 R11 read miss count", lcmd.size(), 1);
        expect_ent("R2 read miss cmd", 0, 0, 1, X, 0);

        clear_log(); do_op(0, 0, X, 0, "R2 read hit data");
        chk("R2 read hit no bus", lcmd.size(), 0);

        clear_log(); do_op(1, 0, X, 0, "R2 second cache read");
        expect_ent("R2 clean read miss", 0, 1, 1, X, 0);

        clear_log(); do_op(0, 1, X, 16'hA001, "R4 upgrade write data");
        chk("R4 one transaction", lcmd.size(), 1);
        expect_ent("R4 invalidate cmd", 0, 0, 3, X, 0);

        clear_log(); do_op(0, 1, X, 16'hA002, "R3 modified write hit");
        chk("R3 write hit no bus", lcmd.size(), 0);

        clear_log(); do_op(1, 0, X, 0, "R5 R6 refetch after invalidate");
        expect_ent("R5 R6 read miss supplied", 0, 1, 1, X, 1);

        clear_log(); do_op(0, 1, X, 16'hA003, "R6 write after supply");
        expect_ent("R6 supplier now shared", 0, 0, 3, X, 0);

        clear_log(); do_op(1, 1, X, 16'hA004, "R3 write miss data");
        expect_ent("R3 R6 write miss supplied", 0, 1, 2, X, 1);

        clear_log(); do_op(0, 0, X, 0, "R5 R6 read after write miss");
        expect_ent("R6 invalidated then refetch", 0, 0, 1, X, 1);

        clear_log(); do_op(1, 1, Z, 16'hB001, "R3 write miss Z");
        expect_ent("R3 write miss cmd", 0, 1, 2, Z, 0);
        clear_log(); do_op(1, 0, Z, 0, "R3 read after write");
        chk("R3 read modified no bus", lcmd.size(), 0);

        clear_log(); do_op(1, 0, Y, 0, "R8 clean victim read");
        chk("R8 no write-back", lcmd.size(), 1);
        expect_ent("R8 R11 read miss Y", 0, 1, 1, Y, 0);

        clear_log(); do_op(1, 1, W, 16'hB002, "R7 dirty victim write");
        chk("R7 two transactions", lcmd.size(), 2);
        expect_ent("R7 write-back first", 0, 1, 4, Z, 0);
        chk("R7 write-back data", (ldata.size() > 0) ? ldata[0] : -1, 16'hB001);
        expect_ent("R7 then write miss", 1, 1, 2, W, 0);
        clear_log(); do_op(0, 0, Z, 0, "R7 memory holds written-back data");
        expect_ent("R7 read from memory", 0, 0, 1, Z, 0);

        do_op(0, 0, V, 0, "R9 setup c0 read");
        do_op(1, 0, V, 0, "R9 setup c1 read");
        clear_log();
        fork
            do_op(0, 1, V, 16'hC000, "R9 loser write data");
            do_op(1, 1, V, 16'hC001, "R9 winner write data");
        join
        refm[V] = 16'hC000;
        chk("R9 two transactions", lcmd.size(), 2);
        expect_ent("R9 winner invalidates", 0, 1, 3, V, 0);
        expect_ent("R9 loser write miss", 1, 0, 2, V, 1);
        clear_log(); do_op(1, 0, V, 0, "R9 winner sees final value");
        expect_ent("R9 refetch from loser", 0, 1, 1, V, 1);
        do_op(0, 0, V, 0, "R9 loser keeps final value");

        do_op(0, 1, X, 16'hD001, "R10 setup dirty X");
        clear_log();
        fork
            do_op(0, 0, Y, 0, "R10 evicting read Y");
            do_op(1, 0, X, 0, "R10 competing read X");
        join
        refm[X] = 16'hD001;
        chk("R10 two transactions", lcmd.size(), 2);
        expect_ent("R10 competitor first", 0, 1, 1, X, 1);
        expect_ent("R10 no write-back", 1, 0, 1, Y, 0);

        repeat (4) @(negedge clk);
        chk("R2 scoreboard drained", q0.size() + q1.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule